// File: doc/BRIEF.md
# Cold/Warm Reset and Power-State Sequencer

This block sits beside a small memory-mapped device and decides what kind of reset the device is in. It samples an active-low reset pin through a synchronizer and measures how long the pin stays low in clock cycles. Once the supply is reported good, the first qualifying pulse must be long. That pulse is the power-on (cold) reset. After that, a much shorter pulse is enough for a warm reset. The two kinds clear different register classes. Only the cold reset sends the flash back to read-array mode.

After the pin is released, a fixed hold interval must pass before memory access is allowed. Any low level on the pin during that interval starts the interval over. A below-lockout supply flag blocks flash writes whatever the sequencer state. A power-down request blocks the programmable-logic address inputs. Requests to enter or leave power-down that arrive while a reset or hold is under way take effect only once the sequence is finished.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `srst` is high, and at the first edge after it falls with `supply_ok` low, `mem_ready` is 0, `io_force_in` is 1, `flash_wr_block` is 1, `logic_out_valid` is 0 and `logic_addr_block` is 0. The three strobes `clr_pm`, `clr_gen` and `flash_rd_cmd` are 0.
- R2: A power-up window opens after `supply_ok` rises and lasts until the first completed cold reset. In that window, a pin-low pulse of at least `COLD_MIN` cycles ends, on release, with one single-cycle pulse on each of `clr_pm`, `clr_gen` and `flash_rd_cmd`. A shorter pulse produces no strobe and leaves the window open with `mem_ready` at 0.
- R3: Once the device is running, a pin-low pulse of at least `WARM_MIN` cycles is a warm reset. It drops `mem_ready` and, on release, gives one `clr_gen` pulse with no `clr_pm` and no `flash_rd_cmd`. A shorter pulse is ignored: `mem_ready` stays 1 and no strobe appears.
- R4: `mem_ready` rises exactly `HOLD_CYC` cycles after the cycle in which `clr_gen` is high. If the pin goes low during the hold, the count starts again from the cycle after the synchronized pin is high again.
- R5: `io_force_in` is 1 with the supply off, in the power-up window, during a warm reset and during the hold. It is 0 while running and in power-down.
- R6: `flash_wr_block` is 1 on the cycle after `below_lockout` is high, in every state. It is also 1 whenever `mem_ready` is 0.
- R7: `logic_out_valid` is 0 after supply loss or `srst` until `cfg_loaded` is seen with the supply good. From then on it stays 1, through warm resets included.
- R8: While running, `pwrdn_req` high enters power-down. There `logic_addr_block` is 1, `mem_ready` is 0 and `io_force_in` is 0. Dropping `pwrdn_req` returns to running with `mem_ready` 1.
- R9: A `pwrdn_req` raised during a warm reset or its hold does not set `logic_addr_block` until the hold has ended. It then takes effect on the cycle at which `mem_ready` would otherwise have risen.
- R10: `supply_ok` low returns the block to the supply-off state, with `mem_ready` 0 and `logic_out_valid` 0. After the supply returns, a warm-length pulse is not enough and a full cold pulse is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous active-high reset of the sequencer |
| rst_pin_n | input | 1 | Asynchronous active-low device reset pin |
| supply_ok | input | 1 | Supply is stable and above its operating minimum |
| below_lockout | input | 1 | Supply is under the flash write lockout threshold |
| pwrdn_req | input | 1 | Power-down request |
| cfg_loaded | input | 1 | Internal configuration load has completed |
| clr_pm | output | 1 | One-cycle clear strobe for power-management registers |
| clr_gen | output | 1 | One-cycle clear strobe for all other registers |
| flash_rd_cmd | output | 1 | One-cycle command returning the flash to read-array mode |
| io_force_in | output | 1 | Forces the I/O ports into input mode |
| mem_ready | output | 1 | Memory access allowed |
| flash_wr_block | output | 1 | Inhibits the start of any flash write cycle |
| logic_out_valid | output | 1 | Programmable-logic outputs are valid |
| logic_addr_block | output | 1 | Blocks address inputs to the programmable logic |

## Verification
Suppose the sequencer holds a wrong state, for example it thinks it is running while it is still in the power-up window. Then the next pulse of warm length gives a `clr_gen` strobe without `clr_pm`, within the synchronizer delay after the release, and `mem_ready` rises one hold interval later. A hold counter that is not restarted shows as `mem_ready` rising a known number of cycles too early after a pin glitch in the hold. A corrupted low-width count shows at the very boundary widths (`WARM_MIN-1`/`WARM_MIN` and `COLD_MIN-1`/`COLD_MIN`), as a missing or extra strobe on release. A lost power-down deferral shows as `logic_addr_block` rising while `mem_ready` has not yet reached its scheduled cycle.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,  // supply not good
    ST_COLD = 3'd1,  // power-up window, waiting for a long pulse
    ST_HOLD = 3'd2,  // post-release hold interval
    ST_RUN  = 3'd3,  // operational
    ST_WRST = 3'd4,  // qualified warm reset, pin still low
    ST_PDN  = 3'd5   // power-down
  } seq_st_e;

  function automatic logic st_forces_input(seq_st_e s);
    return (s == ST_OFF) || (s == ST_COLD) || (s == ST_WRST) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/rst_pin_meter.sv
module rst_pin_meter #(
  parameter int SYNC_STG = 2,
  parameter int SAT      = 64,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             pin_n,
  input  logic             clr,
  output logic             pin_lvl,
  output logic             rise,
  output logic [CNT_W-1:0] low_cnt
);

  logic prev_q;

  generate
    if (SYNC_STG > 0) begin : g_sync
      logic [SYNC_STG-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (srst) begin
          sh_q <= '1;
        end else begin
          sh_q[0] <= pin_n;
          for (int i = 1; i < SYNC_STG; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign pin_lvl = sh_q[SYNC_STG-1];
    end else begin : g_nosync
      assign pin_lvl = pin_n;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (srst) begin
      prev_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      prev_q <= pin_lvl;
      if (clr || pin_lvl) begin
        low_cnt <= '0;
      end else if (low_cnt != CNT_W'(SAT)) begin
        low_cnt <= low_cnt + 1'b1;
      end
    end
  end

  assign rise = pin_lvl & ~prev_q;

  // R3
  low_sat_chk: assert property (@(posedge clk) disable iff (srst)
    low_cnt <= CNT_W'(SAT));

  // R2
  rise_clears_chk: assert property (@(posedge clk) disable iff (srst)
    rise |=> (low_cnt == '0));

endmodule

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int HOLD_CYC = 20
) (
  input  logic clk,
  input  logic srst,
  input  logic run_en,
  output logic done
);

  localparam int HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (srst || !run_en) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run_en && (cnt_q == HW'(HOLD_CYC - 1));

  // R4
  hold_range_chk: assert property (@(posedge clk) disable iff (srst)
    cnt_q < HW'(HOLD_CYC));

  // R4
  hold_restart_chk: assert property (@(posedge clk) disable iff (srst)
    !run_en |=> (cnt_q == '0));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int SYNC_STG = 2,
  parameter int COLD_MIN = 64,
  parameter int WARM_MIN = 8,
  parameter int HOLD_CYC = 20
) (
  input  logic clk,
  input  logic srst,
  input  logic rst_pin_n,
  input  logic supply_ok,
  input  logic below_lockout,
  input  logic pwrdn_req,
  input  logic cfg_loaded,
  output logic clr_pm,
  output logic clr_gen,
  output logic flash_rd_cmd,
  output logic io_force_in,
  output logic mem_ready,
  output logic flash_wr_block,
  output logic logic_out_valid,
  output logic logic_addr_block
);
  import rst_seq_pkg::*;

  localparam int CNT_W = $clog2(COLD_MIN + 1);

  seq_st_e          st_q, st_nx;
  logic             pin_lvl, pin_rise;
  logic [CNT_W-1:0] low_cnt;
  logic             hold_done, warm_qual, cold_ok;
  logic             cold_done, warm_done;

  rst_pin_meter #(
    .SYNC_STG (SYNC_STG),
    .SAT      (COLD_MIN),
    .CNT_W    (CNT_W)
  ) u_meter (
    .clk     (clk),
    .srst    (srst),
    .pin_n   (rst_pin_n),
    .clr     (!supply_ok),
    .pin_lvl (pin_lvl),
    .rise    (pin_rise),
    .low_cnt (low_cnt)
  );

  rst_hold_timer #(
    .HOLD_CYC (HOLD_CYC)
  ) u_hold (
    .clk    (clk),
    .srst   (srst),
    .run_en ((st_q == ST_HOLD) && pin_lvl),
    .done   (hold_done)
  );

  assign warm_qual = !pin_lvl && (low_cnt >= CNT_W'(WARM_MIN - 1));
  assign cold_ok   = pin_rise && (low_cnt >= CNT_W'(COLD_MIN));

  always_comb begin
    st_nx     = st_q;
    cold_done = 1'b0;
    warm_done = 1'b0;
    if (!supply_ok) begin
      st_nx = ST_OFF;
    end else begin
      case (st_q)
        ST_OFF:  st_nx = ST_COLD;
        ST_COLD: if (cold_ok) begin
                   st_nx     = ST_HOLD;
                   cold_done = 1'b1;
                 end
        ST_HOLD: if (warm_qual)      st_nx = ST_WRST;
                 else if (hold_done) st_nx = pwrdn_req ? ST_PDN : ST_RUN;
        ST_RUN:  if (warm_qual)                 st_nx = ST_WRST;
                 else if (pwrdn_req && pin_lvl) st_nx = ST_PDN;
        ST_PDN:  if (warm_qual)                  st_nx = ST_WRST;
                 else if (!pwrdn_req && pin_lvl) st_nx = ST_RUN;
        ST_WRST: if (pin_lvl) begin
                   st_nx     = ST_HOLD;
                   warm_done = 1'b1;
                 end
        default: st_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      st_q             <= ST_OFF;
      clr_pm           <= 1'b0;
      clr_gen          <= 1'b0;
      flash_rd_cmd     <= 1'b0;
      io_force_in      <= 1'b1;
      mem_ready        <= 1'b0;
      flash_wr_block   <= 1'b1;
      logic_out_valid  <= 1'b0;
      logic_addr_block <= 1'b0;
    end else begin
      st_q             <= st_nx;
      clr_pm           <= cold_done;
      clr_gen          <= cold_done | warm_done;
      flash_rd_cmd     <= cold_done;
      io_force_in      <= st_forces_input(st_nx);
      mem_ready        <= (st_nx == ST_RUN);
      flash_wr_block   <= below_lockout | (st_nx != ST_RUN);
      logic_addr_block <= (st_nx == ST_PDN);
      if (!supply_ok)      logic_out_valid <= 1'b0;
      else if (cfg_loaded) logic_out_valid <= 1'b1;
    end
  end

  // R2
  cold_origin_chk: assert property (@(posedge clk) disable iff (srst)
    clr_pm |-> ($past(st_q) == ST_COLD));

  // R3
  warm_origin_chk: assert property (@(posedge clk) disable iff (srst)
    (clr_gen && !clr_pm) |-> ($past(st_q) == ST_WRST));

  // R4
  ready_after_hold_chk: assert property (@(posedge clk) disable iff (srst)
    $rose(mem_ready) |-> ($past(st_q) == ST_HOLD || $past(st_q) == ST_PDN));

  // R5
  ready_io_chk: assert property (@(posedge clk) disable iff (srst)
    mem_ready |-> !io_force_in);

  // R6
  lockout_chk: assert property (@(posedge clk) disable iff (srst)
    below_lockout |=> flash_wr_block);

  // R8
  pdn_outputs_chk: assert property (@(posedge clk) disable iff (srst)
    logic_addr_block |-> (!mem_ready && !io_force_in));

  // R9
  pdn_entry_chk: assert property (@(posedge clk) disable iff (srst)
    $rose(logic_addr_block) |-> ($past(st_q) == ST_HOLD || $past(st_q) == ST_RUN));

endmodule

// File: tb/rst_seq_ctrl_test.sv
`timescale 1ns/1ps
module rst_seq_ctrl_test;

  localparam int COLD = 64;
  localparam int WARM = 8;
  localparam int HOLD = 20;
  localparam int SYNC = 2;

  // {pulse width, expect warm reset}
  localparam logic [8:0] WVEC [6] = '{
    {8'd1,  1'b0}, {8'd7,  1'b0}, {8'd8, 1'b1},
    {8'd15, 1'b1}, {8'd2,  1'b0}, {8'd40, 1'b1}
  };

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic rst_pin_n = 1'b1;
  logic supply_ok = 1'b0;
  logic below_lockout = 1'b0;
  logic pwrdn_req = 1'b0;
  logic cfg_loaded = 1'b0;
  logic clr_pm, clr_gen, flash_rd_cmd, io_force_in, mem_ready;
  logic flash_wr_block, logic_out_valid, logic_addr_block;

  int n_chk = 0, n_bad = 0;
  int n_pm = 0, n_gen = 0, n_rd = 0, n_rdy_lo = 0;
  bit fin = 0;

  always #4 clk = ~clk;

  rst_seq_ctrl #(.SYNC_STG(SYNC), .COLD_MIN(COLD), .WARM_MIN(WARM), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .srst(srst), .rst_pin_n(rst_pin_n), .supply_ok(supply_ok),
    .below_lockout(below_lockout), .pwrdn_req(pwrdn_req), .cfg_loaded(cfg_loaded),
    .clr_pm(clr_pm), .clr_gen(clr_gen), .flash_rd_cmd(flash_rd_cmd),
    .io_force_in(io_force_in), .mem_ready(mem_ready), .flash_wr_block(flash_wr_block),
    .logic_out_valid(logic_out_valid), .logic_addr_block(logic_addr_block)
  );

  always @(negedge clk) begin
    if (clr_pm)       n_pm++;
    if (clr_gen)      n_gen++;
    if (flash_rd_cmd) n_rd++;
    if (!mem_ready)   n_rdy_lo++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_low(input int n);
    @(negedge clk) rst_pin_n = 1'b0;
    repeat (n) @(negedge clk);
    rst_pin_n = 1'b1;
  endtask

  task automatic wait_gen(output int ok);
    ok = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (clr_gen) begin ok = 1; return; end
    end
  endtask

  task automatic count_ready(output int k);
    k = 0;
    while (!mem_ready && k < 500) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ok, k, pm0, gen0, rd0;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 mem_ready", mem_ready, 0);
    chk("R1 io_force_in", io_force_in, 1);
    chk("R1 flash_wr_block", flash_wr_block, 1);
    chk("R1 logic_out_valid", logic_out_valid, 0);
    chk("R1 logic_addr_block", logic_addr_block, 0);
    srst = 1'b0;
    @(negedge clk);
    chk("R1 strobes", n_pm + n_gen + n_rd, 0);
    chk("R1 after release io", io_force_in, 1);

    // R2: power-up, pulse one short of cold minimum extends window
    supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    pulse_low(COLD - 1);
    repeat (HOLD + 15) @(negedge clk);
    chk("R2 short cold strobes", n_pm + n_gen + n_rd, 0);
    chk("R2 short cold ready", mem_ready, 0);
    chk("R5 window io", io_force_in, 1);
    chk("R7 valid before cfg", logic_out_valid, 0);
    cfg_loaded = 1'b1;
    @(negedge clk) cfg_loaded = 1'b0;
    @(negedge clk);
    chk("R7 valid after cfg", logic_out_valid, 1);

    // R2/R4: exact cold minimum
    pulse_low(COLD);
    wait_gen(ok);
    chk("R2 cold strobe seen", ok, 1);
    count_ready(k);
    chk("R2 clr_pm", n_pm, 1);
    chk("R2 clr_gen", n_gen, 1);
    chk("R2 flash_rd_cmd", n_rd, 1);
    chk("R4 hold length", k, HOLD);
    chk("R5 run io", io_force_in, 0);
    chk("R6 run wr_block", flash_wr_block, 0);

    // R3: warm pulse widths from the table
    for (int v = 0; v < 6; v++) begin
      int w;
      bit e;
      w = int'(WVEC[v][8:1]);
      e = WVEC[v][0];
      pm0 = n_pm; gen0 = n_gen; rd0 = n_rd;
      n_rdy_lo = 0;
      pulse_low(w);
      repeat (HOLD + 20) @(negedge clk);
      chk("R3 gen delta", n_gen - gen0, int'(e));
      chk("R3 pm delta", n_pm - pm0, 0);
      chk("R3 rd delta", n_rd - rd0, 0);
      chk("R3 ready dropped", int'(n_rdy_lo != 0), int'(e));
      chk("R3 ready back", mem_ready, 1);
    end

    // R3/R5/R7/R6: observe during a held warm reset
    gen0 = n_gen; pm0 = n_pm;
    @(negedge clk) rst_pin_n = 1'b0;
    repeat (14) @(negedge clk);
    chk("R5 warm io", io_force_in, 1);
    chk("R3 warm ready", mem_ready, 0);
    chk("R7 warm valid", logic_out_valid, 1);
    chk("R6 warm wr_block", flash_wr_block, 1);
    rst_pin_n = 1'b1;
    wait_gen(ok);
    count_ready(k);
    chk("R4 warm hold", k, HOLD);
    chk("R3 warm gen", n_gen - gen0, 1);
    chk("R3 warm pm", n_pm - pm0, 0);

    // R4: glitch during hold restarts the interval
    pulse_low(12);
    wait_gen(ok);
    repeat (4) @(negedge clk);
    pulse_low(3);
    k = 0;
    count_ready(k);
    chk("R4 restarted hold", k + 8, HOLD + 5 + 3 + SYNC);

    // R6: lockout while running
    @(negedge clk) below_lockout = 1'b1;
    @(negedge clk);
    chk("R6 lockout blocks", flash_wr_block, 1);
    chk("R6 lockout ready", mem_ready, 1);
    below_lockout = 1'b0;
    @(negedge clk);
    chk("R6 lockout released", flash_wr_block, 0);

    // R8: power-down
    pwrdn_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 addr block", logic_addr_block, 1);
    chk("R8 ready low", mem_ready, 0);
    chk("R8 io unchanged", io_force_in, 0);
    pwrdn_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 exit addr", logic_addr_block, 0);
    chk("R8 exit ready", mem_ready, 1);

    // R9: power-down requested during warm reset is deferred
    @(negedge clk) rst_pin_n = 1'b0;
    repeat (12) @(negedge clk);
    pwrdn_req = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 deferred in reset", logic_addr_block, 0);
    rst_pin_n = 1'b1;
    wait_gen(ok);
    repeat (HOLD - 1) @(negedge clk);
    chk("R9 deferred in hold", logic_addr_block, 0);
    @(negedge clk);
    chk("R9 applied after hold", logic_addr_block, 1);
    pwrdn_req = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 back to run", mem_ready, 1);

    // R10: supply loss
    @(negedge clk) supply_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 ready", mem_ready, 0);
    chk("R10 valid", logic_out_valid, 0);
    chk("R10 io", io_force_in, 1);
    supply_ok = 1'b1;
    repeat (3) @(negedge clk);
    gen0 = n_gen; pm0 = n_pm;
    pulse_low(12);
    repeat (HOLD + 20) @(negedge clk);
    chk("R10 warm pulse ignored gen", n_gen - gen0, 0);
    chk("R10 warm pulse ignored ready", mem_ready, 0);
    pulse_low(COLD + 6);
    repeat (HOLD + 20) @(negedge clk);
    chk("R10 cold again pm", n_pm - pm0, 1);
    chk("R10 cold again ready", mem_ready, 1);

    fin = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule